// File: doc/BRIEF.md
# SRAM Error-Flag Recovery Sequencer

This block sits on the host side of an asynchronous word-wide SRAM that corrects errors internally and reports an uncorrectable (or configured) bit error on a single flag pin. It accepts word reads and writes from a simple valid/ready request port and turns each one into chip-enable, output-enable and write-enable activity on the memory pins. It remembers the address of the most recent read that finished with the flag low.

When a read finishes with the flag high, the sequencer returns the read word and then runs a fixed recovery sequence. The sequence puts the memory into a state where the flag can be cleared, and it never passes through a pin combination that the memory would treat as a control-register write. The order of the sequence is fixed. First the chip is deselected while output enable is still low. Next output enable is raised. Then the address moves to the last error-free location and is held there for a programmable time. The chip is then selected again with output enable still high. Finally a read controlled by output enable is made at the error-free address. The flag is sampled after a programmable wait. After that, a one-cycle event carries the failing address upward. If the flag did not clear, a sticky fault is set.

Deselection uses the active-high chip enable by default, which leaves background scrubbing running. A parameter selects the active-low chip enable instead.

Top module: `sram_flag_recovery_ctrl`

## Requirements
- R1: After reset, req_ready is 1, mem_oe_n and mem_we_n are 1, the memory is deselected (mem_ce2 = 0 with mem_ce1_n = 0 in the default variant), and err_event, fault and rsp_valid are 0.
- R2: An accepted write (req_write = 1) selects the chip with mem_oe_n = 1, drives mem_dq_oe = 1 with req_wdata on mem_dq_out at req_addr, and pulses mem_we_n low for one cycle. A later read of that address returns the written word.
- R3: An accepted read (req_write = 0) selects the chip with mem_oe_n low for exactly cfg_oe_wait+1 cycles. It then raises rsp_valid for one cycle, with rsp_rdata holding mem_dq_in as sampled on the last of those cycles.
- R4: When the flag is high at the end of a read, the memory is first deselected while mem_oe_n stays low. mem_oe_n rises only in a later cycle, while the memory is already deselected.
- R5: During recovery, mem_addr changes only while the memory is deselected with mem_oe_n high, and it moves to the last error-free read address.
- R6: The memory stays deselected with mem_oe_n high for at least cfg_dis_hold+1 cycles. It is then selected again with mem_oe_n still high.
- R7: The recovery read holds mem_oe_n low at the error-free address for cfg_oe_wait+1 cycles and samples the flag in the last of them. err_event follows in the next cycle.
- R8: From the failing read until recovery completes, mem_we_n stays high and req_ready stays low.
- R9: After recovery, err_event is high for exactly one cycle, with err_addr equal to the address of the read that raised the flag.
- R10: If the flag is still high when the recovery read is sampled, fault becomes 1 and stays 1 through later traffic until reset.
- R11: Only reads that finish with the flag low update the error-free address. Writes and failing reads leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dis_hold | input | CW | Extra cycles the memory stays deselected during recovery |
| cfg_oe_wait | input | CW | Extra cycles output enable is held low before sampling |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | DW | Read data |
| mem_addr | output | AW | Memory address pins |
| mem_ce1_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | DW | Data driven to the memory |
| mem_dq_oe | output | 1 | Host drives the data bus when high |
| mem_dq_in | input | DW | Data from the memory |
| mem_err_flag | input | 1 | Error flag from the memory |
| err_event | output | 1 | One-cycle pulse when recovery completes |
| err_addr | output | AW | Address of the read that raised the flag |
| fault | output | 1 | Sticky: the flag did not clear on recovery |

## Verification
The bench builds the block with a 6-bit address, 16-bit data and 8-bit counters. This lets a behavioural 64-word memory model with a latched error flag sit directly on the pins. Keeping the counters short lets the bench change cfg_dis_hold and cfg_oe_wait between scenarios: one run uses a hold of 3 with a wait of 2, and another uses a hold of 0 with a wait of 1. The hold-of-0 case reaches the shortest legal deselect window. The fault path is reached by making the model's flag refuse to clear.

// File: rtl/sram_flag_recovery_ctrl.sv
module sram_flag_recovery_ctrl #(
  parameter int AW = 19,
  parameter int DW = 32,
  parameter int CW = 16,
  parameter bit DIS_VIA_CE1 = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_dis_hold,
  input  logic [CW-1:0] cfg_oe_wait,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce1_n,
  output logic          mem_ce2,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in,
  input  logic          mem_err_flag,
  output logic          err_event,
  output logic [AW-1:0] err_addr,
  output logic          fault
);

  typedef enum logic [3:0] {
    S_IDLE, S_WSET, S_WPUL, S_RD, S_DIS, S_OEH, S_HOLD, S_EN, S_RRD
  } st_t;

  st_t           state;
  logic [AW-1:0] cur_addr, good_addr;
  logic [DW-1:0] wdata;
  logic [CW-1:0] cnt;

  logic chip_on, oe_low, in_rec, pins_on;

  assign chip_on = state inside {S_WSET, S_WPUL, S_RD, S_EN, S_RRD};
  assign oe_low  = state inside {S_RD, S_DIS, S_RRD};
  assign in_rec  = state inside {S_DIS, S_OEH, S_HOLD, S_EN, S_RRD};

  generate
    if (DIS_VIA_CE1) begin : g_ce1
      assign mem_ce1_n = !chip_on;
      assign mem_ce2   = 1'b1;
    end else begin : g_ce2
      assign mem_ce1_n = 1'b0;
      assign mem_ce2   = chip_on;
    end
  endgenerate

  assign req_ready  = (state == S_IDLE);
  assign mem_oe_n   = !oe_low;
  assign mem_we_n   = (state != S_WPUL);
  assign mem_dq_oe  = state inside {S_WSET, S_WPUL};
  assign mem_dq_out = wdata;
  assign mem_addr   = (state inside {S_HOLD, S_EN, S_RRD}) ? good_addr : cur_addr;
  assign pins_on    = !mem_ce1_n && mem_ce2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cur_addr  <= '0;
      good_addr <= '0;
      wdata     <= '0;
      cnt       <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      err_event <= 1'b0;
      err_addr  <= '0;
      fault     <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      err_event <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          cur_addr <= req_addr;
          wdata    <= req_wdata;
          cnt      <= '0;
          state    <= req_write ? S_WSET : S_RD;
        end
        S_WSET: state <= S_WPUL;
        S_WPUL: state <= S_IDLE;
        S_RD: if (cnt == cfg_oe_wait) begin
          cnt       <= '0;
          rsp_valid <= 1'b1;
          rsp_rdata <= mem_dq_in;
          if (mem_err_flag) state <= S_DIS;
          else begin
            good_addr <= cur_addr;
            state     <= S_IDLE;
          end
        end else cnt <= cnt + 1'b1;
        S_DIS: state <= S_OEH;
        S_OEH: begin
          cnt   <= '0;
          state <= S_HOLD;
        end
        S_HOLD: if (cnt == cfg_dis_hold) begin
          cnt   <= '0;
          state <= S_EN;
        end else cnt <= cnt + 1'b1;
        S_EN: state <= S_RRD;
        S_RRD: if (cnt == cfg_oe_wait) begin
          cnt       <= '0;
          err_event <= 1'b1;
          err_addr  <= cur_addr;
          if (mem_err_flag) fault <= 1'b1;
          state     <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r4_oe_rises_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rec && $rose(mem_oe_n)) |-> (!pins_on && $past(!pins_on)));

  a_r5_addr_moves_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rec && $past(in_rec) && !$stable(mem_addr)) |-> (!pins_on && mem_oe_n));

  a_r6_reselect_with_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rec && $rose(pins_on)) |-> mem_oe_n);

  a_r8_no_write_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_rec |-> (mem_we_n && !req_ready));

  a_r9_event_single: assert property (@(posedge clk) disable iff (!rst_n)
    err_event |=> !err_event);

  a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fault) |-> fault);

  a_r3_rsp_after_oe_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(!mem_oe_n && pins_on));

endmodule

// File: tb/sram_flag_recovery_ctrl_tb.sv
module sram_flag_recovery_ctrl_tb_top;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [CW-1:0] cfg_dis_hold = 8'd3, cfg_oe_wait = 8'd2;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
  logic err_event, fault, mem_err_flag;
  logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr, err_addr;

  sram_flag_recovery_ctrl #(.AW(AW), .DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_dis_hold(cfg_dis_hold), .cfg_oe_wait(cfg_oe_wait),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
    .mem_err_flag(mem_err_flag), .err_event(err_event), .err_addr(err_addr), .fault(fault));

  logic [DW-1:0] mem [0:63];
  logic latch = 1'b0, stuck = 1'b0, bad_en = 1'b0;
  logic [AW-1:0] bad_a = '0;
  wire en = !mem_ce1_n && mem_ce2;
  assign mem_dq_in = mem[mem_addr];
  assign mem_err_flag = latch && en && !mem_oe_n;

  initial for (int i = 0; i < 64; i++) mem[i] = DW'(16'hA000 + i);

  always @(posedge clk) begin
    if (en && !mem_we_n && mem_dq_oe) mem[mem_addr] <= mem_dq_out;
    if (en && !mem_oe_n && mem_we_n) begin
      if (bad_en && mem_addr == bad_a) latch <= 1'b1;
      else if (!stuck) latch <= 1'b0;
    end
  end

  int n_chk = 0, n_fail = 0;
  int viol = 0, dis_seen = 0, reen_seen = 0, streak = 0, last_streak = 0;
  int rd_run = 0, last_rd_run = 0, rr_cnt = 0, last_rr = 0;
  bit rr_arm = 0, prev_en = 0, prev_oe_n = 1, last_reen_oe = 0;
  logic [AW-1:0] prev_addr = '0, last_reen_addr = '0;

  always @(negedge clk) if (rst_n) begin
    if (!mem_we_n && latch) viol++;
    if (latch && req_ready && !stuck) viol++;
    if (latch && prev_en && en && mem_addr != prev_addr) viol++;
    if (latch && prev_en && !en && !prev_oe_n) begin
      dis_seen++;
      if (mem_oe_n && !stuck) viol++;
    end
    if (!en && mem_oe_n) streak++;
    else if (!en) streak = 0;
    if (en && !prev_en && latch) begin
      reen_seen++; last_streak = streak; last_reen_addr = mem_addr;
      last_reen_oe = mem_oe_n; rr_arm = 1; rr_cnt = 0;
    end
    if (en) streak = 0;
    if (en && !mem_oe_n) begin
      if (rr_arm) rr_cnt++; else rd_run++;
    end
    if (rsp_valid) begin last_rd_run = rd_run; rd_run = 0; end
    if (err_event) begin last_rr = rr_cnt; rr_arm = 0; end
    prev_en = en; prev_oe_n = mem_oe_n; prev_addr = mem_addr;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    int t = 0;
    do_req(1'b0, a, '0);
    while (!rsp_valid && t < 100) begin @(negedge clk); t++; end
    d = rsp_rdata;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(mem_oe_n && mem_we_n, "R1 oe_n/we_n", {mem_oe_n, mem_we_n}, 3);
    chk(!mem_ce2 && !mem_ce1_n, "R1 deselected", {mem_ce1_n, mem_ce2}, 0);
    chk(!err_event && !fault && !rsp_valid, "R1 status", {err_event, fault, rsp_valid}, 0);
  endtask

  task automatic t_write_read;
    logic [DW-1:0] d;
    int wlow = 0;
    do_req(1'b1, 6'd7, 16'h1234);
    fork
      begin end
    join
    repeat (3) @(negedge clk);
    chk(mem[7] == 16'h1234, "R2 write stored", mem[7], 16'h1234);
    do_read(6'd7, d);
    chk(d == 16'h1234, "R2 readback", d, 16'h1234);
    chk(last_rd_run == int'(cfg_oe_wait) + 1, "R3 oe low cycles", last_rd_run, cfg_oe_wait + 1);
    do_read(6'd40, d);
    chk(d == 16'hA028, "R3 read data", d, 16'hA028);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 6'd3; req_wdata = 16'hBEEF;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) begin
      if (!mem_we_n) wlow++;
      if (!mem_we_n) chk(mem_oe_n && mem_dq_oe && en && mem_addr == 6'd3 && mem_dq_out == 16'hBEEF,
                         "R2 write pins", {mem_oe_n, mem_dq_oe, en}, 7);
      @(negedge clk);
    end
    chk(wlow == 1, "R2 we pulse width", wlow, 1);
  endtask

  task automatic t_recover(input int hold, input int wt, input bit pre_read,
                           input logic [AW-1:0] good, input logic [AW-1:0] bad);
    logic [DW-1:0] d;
    int v0, ds0, re0, t;
    cfg_dis_hold = CW'(hold); cfg_oe_wait = CW'(wt);
    if (pre_read) do_read(good, d);
    v0 = viol; ds0 = dis_seen; re0 = reen_seen;
    bad_en = 1'b1; bad_a = bad;
    do_read(bad, d);
    bad_en = 1'b0;
    t = 0;
    while (!err_event && t < 200) begin @(negedge clk); t++; end
    chk(err_event == 1'b1, "R9 event seen", err_event, 1);
    chk(err_addr == bad, "R9 err_addr", err_addr, bad);
    @(negedge clk);
    chk(err_event == 1'b0, "R9 one cycle", err_event, 0);
    chk(dis_seen == ds0 + 1, "R4 deselect with oe low", dis_seen - ds0, 1);
    chk(reen_seen == re0 + 1, "R6 reselect once", reen_seen - re0, 1);
    chk(last_reen_oe == 1'b1, "R6 oe high at reselect", last_reen_oe, 1);
    chk(last_streak >= hold + 1, "R6 hold length", last_streak, hold + 1);
    chk(last_reen_addr == good, "R5 R11 error-free addr", last_reen_addr, good);
    chk(last_rr == wt + 1, "R7 recovery read cycles", last_rr, wt + 1);
    chk(viol == v0, "R4 R5 R8 ordering violations", viol - v0, 0);
    chk(latch == 1'b0 && fault == 1'b0, "R7 flag cleared", {latch, fault}, 0);
    chk(req_ready == 1'b1, "R8 ready after", req_ready, 1);
  endtask

  task automatic t_r11_write_not_good;
    logic [DW-1:0] d;
    do_read(6'd5, d);
    do_req(1'b1, 6'd9, 16'h5555);
    repeat (3) @(negedge clk);
    t_recover(2, 2, 1'b0, 6'd5, 6'd12);
  endtask

  task automatic t_fault;
    logic [DW-1:0] d;
    int t;
    cfg_dis_hold = 8'd1; cfg_oe_wait = 8'd2;
    do_read(6'd8, d);
    stuck = 1'b1; bad_en = 1'b1; bad_a = 6'd20;
    do_read(6'd20, d);
    bad_en = 1'b0;
    t = 0;
    while (!err_event && t < 200) begin @(negedge clk); t++; end
    chk(err_addr == 6'd20, "R9 err_addr on fault", err_addr, 20);
    @(negedge clk);
    chk(fault == 1'b1, "R10 fault set", fault, 1);
    stuck = 1'b0; latch = 1'b0;
    do_read(6'd8, d);
    chk(d == 16'hA008, "R3 read after fault", d, 16'hA008);
    chk(fault == 1'b1, "R10 fault sticky", fault, 1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fault == 1'b0, "R10 reset clears", fault, 0);
  endtask

  initial begin
    t_reset();
    t_write_read();
    t_recover(3, 2, 1'b1, 6'd11, 6'd33);
    t_recover(0, 1, 1'b1, 6'd2, 6'd60);
    t_r11_write_not_good();
    t_fault();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule